// File: doc/BRIEF.md
# Block Store Controller with Byte Transfer Window

This block is a memory-mapped storage controller for a small 8-bit system. It keeps an internal image of fixed-size 256-byte blocks and a single 256-byte staging buffer. Software reaches everything through a byte-wide register port. One register selects a block and another starts a command. A 256-byte window gives direct access to the staging buffer.

A command either copies the selected block of the image into the staging buffer (load) or copies the staging buffer into the selected block (store). A copy moves one byte per clock, so a whole block takes 256 cycles, and a busy flag stays high for that whole time. While a copy runs, the block is locked and new commands and buffer writes are dropped. Software polls the busy flag or the command register to learn when the data is ready. Block 0 is, by convention, where a file layer keeps its directory; the controller treats every block alike.

Top module: `blkstore_ctrl`

## Requirements
- R1: After reset, busy_o is 0 and reads at offset 0x000, at offset 0x001 and at every staging byte (offsets 0x002 to 0x101) return 0x00.
- R2: A write to offset 0x000 sets the block select. A read of offset 0x000 returns the stored select.
- R3: Offsets 0x002 to 0x101 map one-to-one onto staging bytes 0 to 255. A write stores the byte there when idle, and a read returns it.
- R4: Writing 0x02 to offset 0x001 while idle copies all 256 staging bytes into the selected block of the image.
- R5: Writing 0x01 to offset 0x001 while idle copies all 256 bytes of the selected block into the staging buffer.
- R6: A load or store keeps busy_o high for exactly 256 cycles, starting the cycle after the command write. Offset 0x001 reads 0x01 while busy and 0x00 when idle.
- R7: Writes to the staging window while busy leave the staging buffer unchanged.
- R8: The image holds 16 blocks. Only the low 4 bits of a select are kept, so select 0x13 reads back as 0x03 and addresses block 3.
- R9: Command values other than 0x01 and 0x02 (including 0x00) start nothing. busy_o stays low and the staging buffer keeps its contents.
- R10: Offsets above 0x101 read as 0x00, and writes to them change nothing.
- R11: A command write while busy is ignored: no second copy follows the running one.
- R12: A store to one block leaves every other block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Byte offset into the register space |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable for the addressed byte |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| busy_o | output | 1 | High while a block copy runs |

## Verification
The bench counts the cycles that busy_o stays high. A sequencer that stops one byte early or late gives a count of 255 or 257. It also writes to the staging window and to the command register during a copy. A design that let those writes through would show a changed staging byte, or a second busy period right after the first.

Two blocks are stored with different patterns and then loaded back in turn. A design that mixed block addresses or copied only part of a block would return the wrong pattern. Select 0x13 is used to reach block 3, which exposes a select that is not reduced modulo 16. Offsets just past the window and the command values 0x03 and 0xFF catch decoders that are too loose.

// File: rtl/blkstore_pkg.sv
package blkstore_pkg;

    typedef enum logic [7:0] {
        OP_IDLE  = 8'h00,
        OP_LOAD  = 8'h01,
        OP_STORE = 8'h02
    } blk_op_e;

    typedef enum logic {
        DIR_TO_STAGE = 1'b0,
        DIR_TO_IMAGE = 1'b1
    } copy_dir_e;

endpackage

// File: rtl/blkstore_seq.sv
module blkstore_seq
    import blkstore_pkg::*;
#(
    parameter int BLK_BYTES = 256,
    parameter int NUM_BLKS  = 16,
    localparam int IDX_W    = $clog2(BLK_BYTES),
    localparam int SEL_W    = $clog2(NUM_BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  copy_dir_e        dir_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             busy_o,
    output copy_dir_e        dir_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

    typedef struct packed {
        logic             busy;
        copy_dir_e        dir;
        logic [SEL_W-1:0] sel;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.dir  = dir_i;
            st_d.sel  = sel_i;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, dir: DIR_TO_STAGE, sel: '0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign dir_o  = st_q.dir;
    assign sel_o  = st_q.sel;
    assign idx_o  = st_q.idx;

    // R6
    copy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx == LAST_IDX) |=> !st_q.busy);

    // R6
    copy_begins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.idx == '0 && $past(start_i)));

    // R11
    copy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx != LAST_IDX) |=>
            (st_q.busy && $stable(st_q.sel) && $stable(st_q.dir)));

endmodule

// File: rtl/blkstore_image.sv
module blkstore_image #(
    parameter int BLK_BYTES = 256,
    parameter int NUM_BLKS  = 16,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(BLK_BYTES),
    localparam int SEL_W    = $clog2(NUM_BLKS),
    localparam int DEPTH    = BLK_BYTES * NUM_BLKS
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [SEL_W+IDX_W-1:0] flat_addr;

    assign flat_addr = {sel_i, idx_i};
    assign rdata_o   = store_q[flat_addr];

    always_ff @(posedge clk) begin
        if (we_i) begin
            store_q[flat_addr] <= wdata_i;
        end
    end

endmodule

// File: rtl/blkstore_stage.sv
module blkstore_stage #(
    parameter int BLK_BYTES = 256,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we_i,
    input  logic [IDX_W-1:0]  cpu_idx_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic              copy_we_i,
    input  logic [IDX_W-1:0]  copy_idx_i,
    input  logic [DATA_W-1:0] copy_wdata_i,
    output logic [DATA_W-1:0] copy_rdata_o
);

    logic [DATA_W-1:0] bytes_d [BLK_BYTES];
    logic [DATA_W-1:0] bytes_q [BLK_BYTES];

    always_comb begin
        bytes_d = bytes_q;
        if (copy_we_i) begin
            bytes_d[copy_idx_i] = copy_wdata_i;
        end else if (cpu_we_i) begin
            bytes_d[cpu_idx_i] = cpu_wdata_i;
        end
    end

    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes_q[g] <= '0;
            end else begin
                bytes_q[g] <= bytes_d[g];
            end
        end
    end

    assign cpu_rdata_o  = bytes_q[cpu_idx_i];
    assign copy_rdata_o = bytes_q[copy_idx_i];

    // R7
    stage_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(copy_we_i && cpu_we_i));

endmodule

// File: rtl/blkstore_ctrl.sv
module blkstore_ctrl
    import blkstore_pkg::*;
#(
    parameter int BLK_BYTES = 256,
    parameter int NUM_BLKS  = 16,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);

    localparam int IDX_W = $clog2(BLK_BYTES);
    localparam int SEL_W = $clog2(NUM_BLKS);
    localparam logic [ADDR_W-1:0] OFS_SEL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_OP    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_STAGE = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_LIMIT = ADDR_W'(2 + BLK_BYTES);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              in_stage;
    logic [IDX_W-1:0]  stage_idx;
    logic              start;
    copy_dir_e         start_dir;
    logic              busy;
    copy_dir_e         run_dir;
    logic [SEL_W-1:0]  run_sel;
    logic [IDX_W-1:0]  run_idx;
    logic [DATA_W-1:0] stage_cpu_rd;
    logic [DATA_W-1:0] stage_copy_rd;
    logic [DATA_W-1:0] image_rd;
    logic              stage_cpu_we;
    logic              stage_copy_we;
    logic              image_we;

    assign in_stage  = (addr_i >= OFS_STAGE) && (addr_i < OFS_LIMIT);
    assign stage_idx = IDX_W'(addr_i - OFS_STAGE);

    always_comb begin
        regs_d    = regs_q;
        start     = 1'b0;
        start_dir = DIR_TO_STAGE;
        if (we_i && addr_i == OFS_SEL) begin
            regs_d.sel = wdata_i[SEL_W-1:0];
        end
        if (we_i && addr_i == OFS_OP && !busy) begin
            if (wdata_i == OP_LOAD) begin
                start     = 1'b1;
                start_dir = DIR_TO_STAGE;
            end else if (wdata_i == OP_STORE) begin
                start     = 1'b1;
                start_dir = DIR_TO_IMAGE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign stage_cpu_we  = we_i && in_stage && !busy;
    assign stage_copy_we = busy && (run_dir == DIR_TO_STAGE);
    assign image_we      = busy && (run_dir == DIR_TO_IMAGE);

    blkstore_seq #(
        .BLK_BYTES (BLK_BYTES),
        .NUM_BLKS  (NUM_BLKS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .dir_i   (start_dir),
        .sel_i   (regs_q.sel),
        .busy_o  (busy),
        .dir_o   (run_dir),
        .sel_o   (run_sel),
        .idx_o   (run_idx)
    );

    blkstore_stage #(
        .BLK_BYTES (BLK_BYTES),
        .DATA_W    (DATA_W)
    ) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_we_i     (stage_cpu_we),
        .cpu_idx_i    (stage_idx),
        .cpu_wdata_i  (wdata_i),
        .cpu_rdata_o  (stage_cpu_rd),
        .copy_we_i    (stage_copy_we),
        .copy_idx_i   (run_idx),
        .copy_wdata_i (image_rd),
        .copy_rdata_o (stage_copy_rd)
    );

    blkstore_image #(
        .BLK_BYTES (BLK_BYTES),
        .NUM_BLKS  (NUM_BLKS),
        .DATA_W    (DATA_W)
    ) u_image (
        .clk     (clk),
        .we_i    (image_we),
        .sel_i   (run_sel),
        .idx_i   (run_idx),
        .wdata_i (stage_copy_rd),
        .rdata_o (image_rd)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_SEL) begin
            rdata_o = DATA_W'(regs_q.sel);
        end else if (addr_i == OFS_OP) begin
            rdata_o = DATA_W'(busy);
        end else if (in_stage) begin
            rdata_o = stage_cpu_rd;
        end
    end

    assign busy_o = busy;

    // R10
    past_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= OFS_LIMIT) |-> (rdata_o == '0));

    // R6
    op_reads_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == OFS_OP) |-> (rdata_o == DATA_W'(busy_o)));

    // R8
    sel_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_SEL) |=> (rdata_o[DATA_W-1:SEL_W] == '0 || addr_i != OFS_SEL));

endmodule

// File: tb/tb_blkstore_ctrl.sv
module tb_blkstore_ctrl;

    logic       clk;
    logic       rst_n;
    logic [8:0] addr;
    logic [7:0] wdata;
    logic       we;
    logic [7:0] rdata;
    logic       busy;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    bit req      = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    blkstore_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .wdata_i (wdata),
        .we_i    (we),
        .rdata_o (rdata),
        .busy_o  (busy)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // monitor: pops one expected read per requested sample
    always @(negedge clk) begin
        if (req && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                failures++;
                $display("FAIL %s addr=0x%03h actual=0x%02h expected=0x%02h", t, addr, rdata, e);
            end
        end
    end

    task automatic chk(input int act, input int exp_v, input string t);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp_v);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req = 1'b0;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        req = 1'b0;
        we = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        req = 1'b1;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req = 1'b0;
        addr = 9'h000; we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic logic [7:0] pat_a(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] pat_b(int i);
        return 8'(i * 3 + 1);
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int n;
        addr = '0; wdata = '0; we = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        idle();
        chk(int'(busy), 0, "R1 busy after reset");
        rd(9'h000, 8'h00, "R1 select after reset");
        rd(9'h001, 8'h00, "R1 op reg after reset");
        rd(9'h002, 8'h00, "R1 first stage byte");
        rd(9'h101, 8'h00, "R1 last stage byte");

        // R2 select register
        wr(9'h000, 8'h05);
        rd(9'h000, 8'h05, "R2 select readback");

        // R3 stage window fill and readback
        for (int i = 0; i < 256; i++) wr(9'(2 + i), pat_a(i));
        rd(9'h002, pat_a(0), "R3 byte 0");
        rd(9'h081, pat_a(127), "R3 byte 127");
        rd(9'h101, pat_a(255), "R3 byte 255");

        // R4 R6 store to block 5, count busy cycles
        wr(9'h001, 8'h02);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
        chk(n, 256, "R6 busy length of store");
        rd(9'h001, 8'h00, "R6 op reg idle");

        // R6 R7 R11 second store: op reads 1, stage writes and new ops dropped
        wr(9'h001, 8'h02);
        rd(9'h001, 8'h01, "R6 op reg while busy");
        wr(9'h002, 8'hEE);
        wr(9'h101, 8'hEE);
        wr(9'h001, 8'h01);
        wait_idle();
        idle();
        chk(int'(busy), 0, "R11 no copy after busy write of op");
        rd(9'h002, pat_a(0), "R7 stage byte 0 unchanged");
        rd(9'h101, pat_a(255), "R7 stage byte 255 unchanged");

        // R8 R12 store pattern B into block 3 through select 0x13
        for (int i = 0; i < 256; i++) wr(9'(2 + i), pat_b(i));
        wr(9'h000, 8'h13);
        rd(9'h000, 8'h03, "R8 select keeps low four bits");
        wr(9'h001, 8'h02);
        wait_idle();

        // R5 R12 load block 5 back, expect pattern A
        wr(9'h000, 8'h05);
        wr(9'h001, 8'h01);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(posedge clk); #1;
        end
        chk(n, 256, "R6 busy length of load");
        for (int i = 0; i < 256; i++) rd(9'(2 + i), pat_a(i), "R5 R12 load of block 5");

        // R8 block 3 via select 3: expect pattern B
        wr(9'h000, 8'h03);
        wr(9'h001, 8'h01);
        wait_idle();
        for (int i = 0; i < 256; i += 17) rd(9'(2 + i), pat_b(i), "R8 load of block 3");
        rd(9'h101, pat_b(255), "R8 last byte of block 3");

        // R9 unknown ops do nothing
        wr(9'h000, 8'h05);
        wr(9'h001, 8'h03);
        chk(int'(busy), 0, "R9 op 0x03 idle");
        wr(9'h001, 8'hFF);
        chk(int'(busy), 0, "R9 op 0xFF idle");
        wr(9'h001, 8'h00);
        chk(int'(busy), 0, "R9 op 0x00 idle");
        rd(9'h002, pat_b(0), "R9 stage unchanged");
        rd(9'h001, 8'h00, "R9 op reg idle");

        // R10 offsets past the window
        wr(9'h102, 8'hA5);
        rd(9'h102, 8'h00, "R10 offset 0x102");
        rd(9'h1FF, 8'h00, "R10 offset 0x1FF");
        rd(9'h101, pat_b(255), "R10 stage end unchanged");
        rd(9'h000, 8'h05, "R10 select unchanged");

        idle();
        idle();
        report();
    end

endmodule